// File: doc/BRIEF.md
# Framed Serial Codec Register Slave

This block is the device-side end of a framed, synchronous serial control link. It holds a bank of sixteen 16-bit registers. A host addresses one register per frame and asks for either a read or a write. Every frame sends the addressed register's contents back to the host, whatever the access type. The read value is captured as soon as the access-type flag arrives in mid-frame, so it returns in the same frame. A write commits only after the whole first subframe has been received. A write frame therefore echoes the value the register held before the write, and the new value appears in the following frame. Each register is also visible on a flat parallel debug bus.

A one-cycle frame-sync pulse marks bit 1 of a frame. The block samples `frm_sync` and `sdi` on the rising edge of `clk` and changes `sdo` on the falling edge. The bit number of each field is fixed, because the host decodes the same positions:

| Bits | Field |
|------|-------|
| 37–40 | address, MSB first |
| 41 | flag: 1 = write, 0 = read |
| 49–64 | write data, MSB first; return data is driven in the same slots |
| 65 | commit point |

All other bit slots are don't-care. A frame lasts `FRAME_BITS` bits (default 128).

A small sequencer tracks the phase of the bit just sampled. It has eight states:

- **IDLE**: no frame is in progress.
- **HEAD**: bits 1–36.
- **ADDR**: bits 37–40.
- **FLAG**: bit 41.
- **GAP**: bits 42–48.
- **DATA**: bits 49–64.
- **COMMIT**: bit 65.
- **TAIL**: bit 66 up to `FRAME_BITS`.

Its transitions are:

- **sync**: any state goes to HEAD with bit count 1 when `frm_sync` is high.
- **HEAD→ADDR**: after bit 36.
- **ADDR→FLAG**: after bit 40.
- **FLAG→GAP**: always.
- **GAP→DATA**: after bit 48.
- **DATA→COMMIT**: after bit 64.
- **COMMIT→TAIL**: always.
- **TAIL→IDLE**: after bit `FRAME_BITS` when no sync arrives.

Otherwise each state holds and the bit count advances. IDLE holds without counting.

Top module: `codec_reg_slave`

## Requirements
- R1: After an active-low reset, every register reads zero on the debug bus and `sdo` is low.
- R2: A rising edge with `frm_sync` high samples bit 1. The address is taken from bits 37–40 with bit 37 as its MSB, and the sequence restarts on every sync pulse.
- R3: The flag sampled at bit 41 selects the access: 1 is a write, 0 is a read.
- R4: In every frame, the addressed register's value at the moment bit 41 is sampled is driven on `sdo` in bits 49–64, MSB at bit 49. Each bit is set on the falling edge before the rising edge that samples it.
- R5: In a write frame, the returned value is the register's previous contents. The data from bits 49–64 is stored when bit 65 is sampled, and the next frame returns it.
- R6: A read frame changes no register, whatever its data slots carry.
- R7: A register changes only on the rising edge that samples bit 65 of a write frame. A sync pulse that arrives before bit 65 abandons the frame without a write.
- R8: `sdo` is low in every bit slot outside 49–64.
- R9: If no sync arrives by bit `FRAME_BITS`, the block returns to IDLE. It then keeps `sdo` low and the registers unchanged until the next sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_sync | input | 1 | Frame start pulse, high during bit 1 |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| dbg_regs | output | 256 | All registers, register n in bits [16n+15:16n] |

## Verification
The assertions assume that `frm_sync` is a single-cycle pulse and that the host keeps it low within a frame, except when it deliberately restarts. They also assume that `sdi` and `frm_sync` settle between edges. The bench changes both inputs only on the falling edge and raises sync only on bit 1 of each frame. It restarts early only in the abort scenarios, where the sync-qualified output check still applies. It samples `sdo` one nanosecond after the falling edge, which is when the bit slot being presented becomes valid.

// File: rtl/csl_pkg.sv
`timescale 1ns/1ps
package csl_pkg;
    // Bit numbers shared with the host side of the link
    localparam int FLAG_BIT   = 41;
    localparam int COMMIT_BIT = 65;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_ADDR,
        ST_FLAG,
        ST_GAP,
        ST_DATA,
        ST_COMMIT,
        ST_TAIL
    } phase_e;
endpackage

// File: rtl/csl_frame_fsm.sv
`timescale 1ns/1ps
module csl_frame_fsm
    import csl_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int FRAME_BITS = 128,
    parameter int PW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_sync,
    output phase_e        state_q,
    output phase_e        nxt_state,
    output logic [PW-1:0] pos_q,
    output logic          cap_addr,
    output logic          cap_flag,
    output logic          cap_data,
    output logic          commit
);
    localparam int ADDR_FIRST = FLAG_BIT - ADDR_W;
    localparam int DATA_FIRST = COMMIT_BIT - DATA_W;

    logic [PW-1:0] nxt_pos;

    // next phase = phase of the bit sampled at the coming rising edge
    always_comb begin
        nxt_state = state_q;
        nxt_pos   = pos_q;
        if (frm_sync) begin
            nxt_state = ST_HEAD;
            nxt_pos   = PW'(1);
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HEAD: begin
                    nxt_pos = pos_q + 1'b1;
                    if (pos_q == PW'(ADDR_FIRST - 1)) nxt_state = ST_ADDR;
                end
                ST_ADDR: begin
                    nxt_pos = pos_q + 1'b1;
                    if (pos_q == PW'(FLAG_BIT - 1)) nxt_state = ST_FLAG;
                end
                ST_FLAG: begin
                    nxt_pos   = pos_q + 1'b1;
                    nxt_state = ST_GAP;
                end
                ST_GAP: begin
                    nxt_pos = pos_q + 1'b1;
                    if (pos_q == PW'(DATA_FIRST - 1)) nxt_state = ST_DATA;
                end
                ST_DATA: begin
                    nxt_pos = pos_q + 1'b1;
                    if (pos_q == PW'(COMMIT_BIT - 1)) nxt_state = ST_COMMIT;
                end
                ST_COMMIT: begin
                    nxt_pos   = pos_q + 1'b1;
                    nxt_state = ST_TAIL;
                end
                ST_TAIL: begin
                    if (pos_q == PW'(FRAME_BITS)) begin
                        nxt_state = ST_IDLE;
                        nxt_pos   = '0;
                    end else begin
                        nxt_pos = pos_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= nxt_state;
            pos_q   <= nxt_pos;
        end
    end

    // strobes for the bit arriving at the coming edge
    always_comb begin
        cap_addr = (nxt_state == ST_ADDR);
        cap_flag = (nxt_state == ST_FLAG);
        cap_data = (nxt_state == ST_DATA);
        commit   = (nxt_state == ST_COMMIT);
    end
endmodule

// File: rtl/csl_field_capture.sv
`timescale 1ns/1ps
module csl_field_capture #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              cap_addr,
    input  logic              cap_flag,
    input  logic              cap_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
            data_q <= '0;
        end else begin
            if (cap_addr) addr_q <= {addr_q[ADDR_W-2:0], sdi};
            if (cap_flag) wr_q   <= sdi;
            if (cap_data) data_q <= {data_q[DATA_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/csl_reg_bank.sv
`timescale 1ns/1ps
module csl_reg_bank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int NREGS  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NREGS*DATA_W-1:0] dbg
);
    logic [DATA_W-1:0] regs [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata = regs[addr];

    for (genvar g = 0; g < NREGS; g++) begin : g_view
        assign dbg[g*DATA_W +: DATA_W] = regs[g];
    end
endmodule

// File: rtl/csl_return_path.sv
`timescale 1ns/1ps
module csl_return_path
    import csl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_flag,
    input  logic [DATA_W-1:0] rdata,
    input  phase_e            state_q,
    input  logic [PW-1:0]     pos_q,
    output logic              sdo
);
    localparam int DATA_FIRST = COMMIT_BIT - DATA_W;
    localparam int IDX_W      = $clog2(DATA_W);

    logic [DATA_W-1:0] ret_q;
    logic              drive_now;
    logic [IDX_W-1:0]  idx;

    // snapshot taken on the flag bit, before any commit of this frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ret_q <= '0;
        else if (cap_flag) ret_q <= rdata;
    end

    // the next slot (pos_q + 1) lies inside the data window
    always_comb begin
        drive_now = ((state_q == ST_GAP)  && (pos_q == PW'(DATA_FIRST - 1))) ||
                    ((state_q == ST_DATA) && (pos_q != PW'(COMMIT_BIT - 1)));
        idx       = IDX_W'(PW'(COMMIT_BIT - 2) - pos_q);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)         sdo <= 1'b0;
        else if (drive_now) sdo <= ret_q[idx];
        else                sdo <= 1'b0;
    end
endmodule

// File: rtl/codec_reg_slave.sv
`timescale 1ns/1ps
module codec_reg_slave
    import csl_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int FRAME_BITS = 128,
    localparam int NREGS     = 1 << ADDR_W,
    localparam int PW        = $clog2(FRAME_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_sync,
    input  logic                    sdi,
    output logic                    sdo,
    output logic [NREGS*DATA_W-1:0] dbg_regs
);
    phase_e            state_q;
    phase_e            nxt_state;
    logic [PW-1:0]     pos_q;
    logic              cap_addr;
    logic              cap_flag;
    logic              cap_data;
    logic              commit;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rdata;

    csl_frame_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .PW(PW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync),
        .state_q(state_q), .nxt_state(nxt_state), .pos_q(pos_q),
        .cap_addr(cap_addr), .cap_flag(cap_flag), .cap_data(cap_data),
        .commit(commit)
    );

    csl_field_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sdi(sdi),
        .cap_addr(cap_addr), .cap_flag(cap_flag), .cap_data(cap_data),
        .addr_q(addr_q), .wr_q(wr_q), .data_q(data_q)
    );

    csl_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(commit && wr_q),
        .addr(addr_q), .wdata(data_q), .rdata(rdata), .dbg(dbg_regs)
    );

    csl_return_path #(.DATA_W(DATA_W), .PW(PW)) u_ret (
        .clk(clk), .rst_n(rst_n), .cap_flag(cap_flag), .rdata(rdata),
        .state_q(state_q), .pos_q(pos_q), .sdo(sdo)
    );
endmodule

// File: rtl/csl_checker.sv
`timescale 1ns/1ps
module csl_checker
    import csl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    parameter int PW     = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frm_sync,
    input logic                    sdo,
    input logic [NREGS*DATA_W-1:0] dbg_regs,
    input phase_e                  state_q,
    input phase_e                  nxt_state,
    input logic [PW-1:0]           pos_q,
    input logic [ADDR_W-1:0]       addr_q,
    input logic                    wr_q,
    input logic [DATA_W-1:0]       data_q
);
    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_sync |=> (state_q == ST_HEAD && pos_q == PW'(1))); // R2

    AST_FLAG_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_state == ST_FLAG) |-> (state_q == ST_ADDR && pos_q == PW'(FLAG_BIT - 1))); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_state == ST_COMMIT && wr_q) |=>
        (dbg_regs[$past(addr_q)*DATA_W +: DATA_W] == $past(data_q))); // R5

    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_state == ST_COMMIT && !wr_q) |=> $stable(dbg_regs)); // R6

    AST_NO_WRITE_OFF_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_state != ST_COMMIT) |=> $stable(dbg_regs)); // R7

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_sync && nxt_state != ST_DATA) |-> !sdo); // R8

    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frm_sync) |=> (state_q == ST_IDLE)); // R9
endmodule

bind codec_reg_slave csl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .sdo(sdo),
    .dbg_regs(dbg_regs), .state_q(state_q), .nxt_state(nxt_state),
    .pos_q(pos_q), .addr_q(addr_q), .wr_q(wr_q), .data_q(data_q)
);

// File: tb/codec_reg_slave_tb.sv
`timescale 1ns/1ps
module codec_reg_slave_tb_top;
    localparam int FB = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_sync = 1'b0;
    logic         sdi = 1'b0;
    logic         sdo;
    logic [255:0] dbg_regs;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [16];

    always #2.5 clk = ~clk;

    codec_reg_slave #(.ADDR_W(4), .DATA_W(16), .FRAME_BITS(FB)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .sdi(sdi),
        .sdo(sdo), .dbg_regs(dbg_regs)
    );

    function automatic logic [15:0] reg_of(input int i);
        return dbg_regs[i*16 +: 16];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < 16; i++) check(tag, {16'h0, reg_of(i)}, {16'h0, model[i]});
    endtask

    // Sends bits 1..len of a frame; collects the return word and counts high sdo outside 49..64
    task automatic send(input logic [3:0] a, input logic w, input logic [15:0] d,
                        input logic fill, input int len,
                        output logic [15:0] ret, output int stray);
        ret   = '0;
        stray = 0;
        for (int k = 1; k <= len; k++) begin
            logic b;
            @(negedge clk);
            b = fill;
            if (k >= 37 && k <= 40) b = a[40-k];
            if (k == 41)            b = w;
            if (k >= 49 && k <= 64) b = d[64-k];
            frm_sync = (k == 1);
            sdi      = b;
            #1;
            if (k >= 49 && k <= 64) ret[64-k] = sdo;
            else if (sdo)           stray++;
        end
    endtask

    task automatic t_reset();
        check("R1 sdo after reset", {31'h0, sdo}, 32'h0);
        check_bank("R1 register reset");
    endtask

    task automatic t_write_echo();
        logic [15:0] r; int s;
        send(4'd3, 1'b1, 16'hBEEF, 1'b0, FB, r, s);
        check("R5 write echoes old value", {16'h0, r}, 32'h0);
        check("R8 no stray sdo", s, 0);
        model[3] = 16'hBEEF;
        check_bank("R5 write stored");
    endtask

    task automatic t_read_same_frame();
        logic [15:0] r; int s;
        send(4'd3, 1'b0, 16'h5555, 1'b0, FB, r, s);
        check("R4 read returns in same frame", {16'h0, r}, 32'h0000BEEF);
        check_bank("R3 R6 read leaves bank");
    endtask

    task automatic t_overwrite();
        logic [15:0] r; int s;
        send(4'd3, 1'b1, 16'h1234, 1'b0, FB, r, s);
        check("R5 overwrite echoes previous", {16'h0, r}, 32'h0000BEEF);
        model[3] = 16'h1234;
        send(4'd3, 1'b0, 16'h0000, 1'b0, FB, r, s);
        check("R5 next frame returns new", {16'h0, r}, 32'h00001234);
    endtask

    task automatic t_fields_and_filler();
        logic [15:0] r; int s;
        send(4'd15, 1'b1, 16'hFFFF, 1'b1, FB, r, s);
        check("R5 echo with filler", {16'h0, r}, 32'h0);
        check("R8 filler ones keep sdo low", s, 0);
        model[15] = 16'hFFFF;
        send(4'b1000, 1'b1, 16'h0F0F, 1'b1, FB, r, s);
        model[8] = 16'h0F0F;
        check_bank("R2 address MSB first");
        send(4'd0, 1'b0, 16'hFFFF, 1'b1, FB, r, s);
        check("R4 read zero reg", {16'h0, r}, 32'h0);
        check("R8 read frame stray", s, 0);
        send(4'd8, 1'b0, 16'h0000, 1'b0, FB, r, s);
        check("R4 read reg 8", {16'h0, r}, 32'h00000F0F);
    endtask

    task automatic t_abort();
        logic [15:0] r; int s;
        send(4'd5, 1'b1, 16'hAAAA, 1'b0, 60, r, s);
        send(4'd5, 1'b1, 16'hAAAA, 1'b0, 64, r, s);
        check_bank("R7 aborted write leaves bank");
        send(4'd5, 1'b0, 16'h0000, 1'b0, FB, r, s);
        check("R7 aborted write not visible", {16'h0, r}, 32'h0);
    endtask

    task automatic t_idle();
        logic [15:0] r; int s;
        int highs = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            frm_sync = 1'b0;
            sdi      = 1'b1;
            #1;
            if (sdo) highs++;
        end
        check("R9 idle sdo low", highs, 0);
        check_bank("R9 idle bank unchanged");
        send(4'd3, 1'b0, 16'h0000, 1'b0, FB, r, s);
        check("R9 resume after idle", {16'h0, r}, 32'h00001234);
    endtask

    initial begin
        #500000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_write_echo();
        t_read_same_frame();
        t_overwrite();
        t_fields_and_filler();
        t_abort();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule